// File: doc/BRIEF.md
# Two-Stage Clock Generator Ratio Register Front End

This block sits between a byte-wide register write port and the two frequency-synthesis stages of a clock generator. Software writes a divider and a multiplier for the first stage, a packed divider/multiplier pair for the second stage, and a mode bit that turns on an extra 16/25 scaling in the second stage. The block keeps staged copies of these values. It moves them to its active outputs only when the writes arrive in the required order. Each output ratio is presented already decoded: the stored field plus one.

A commit to either stage starts a settling window for that stage. While the window runs, a busy flag is held high. The window is measured in pulses of a reference-clock enable, `ref_tick`, so a downstream sequencer can wait for the synthesiser to lock before it relies on the new frequency.

The first-stage order is enforced by a two-state sequencer. From `S1_IDLE`, a divider write moves it to `S1_ARMED`. From `S1_ARMED`, a multiplier write commits the pair and returns to `S1_IDLE`. A repeated divider write stays in `S1_ARMED` with the new value. Any other write discards the pending value and returns to `S1_IDLE`. Each settling timer also has two states. `T_IDLE` goes to `T_COUNT` on a load with a non-zero length. A load received while in `T_COUNT` restarts the count. `T_COUNT` goes back to `T_IDLE` when the last reference pulse of the window arrives.

Top module: `clkgen_ratio_regs`

## Requirements
- R1: A synchronous reset clears all fields to zero, so every decoded ratio reads 1. It also clears the active mode, the scaling enable, the error flag, both busy flags and any pending first-stage sequence.
- R2: The first-stage pair commits on the clock edge that samples a write to address 8, but only when the previous write was to address 7. Idle cycles between the two writes are allowed. Both active first-stage ratios change together.
- R3: If a write to any other address comes between the address-7 and address-8 writes, the pending divider is discarded. A write to address 8 without a pending divider leaves the active first-stage ratios unchanged.
- R4: A second write to address 7 before address 8 replaces the pending divider, and the newest value is the one committed.
- R5: Decoded ratios equal the stored field plus one: 0x7C gives 125 and 0x5F gives 96. At address 9, bits [7:4] hold the second-stage divider and bits [3:0] hold the second-stage multiplier.
- R6: Bit 0 of address 10 writes a shadow mode bit. The active mode copies the shadow only on a write to address 9, in the same edge that loads the second-stage fields.
- R7: The 16/25 scaling enable is 1 only after an address-9 commit with shadow mode 1 and a non-zero address-9 byte.
- R8: An address-9 commit with shadow mode 1 and a zero byte sets a sticky error flag. Later commits do not clear it. Writing address 11 with bit 0 at 1 clears it, and bit 0 at 0 leaves it set.
- R9: After a first-stage commit, the stage-one busy flag stays high for LOCK1_TICKS `ref_tick` pulses and then falls. With `ref_tick` low it holds.
- R10: After an address-9 commit, the stage-two busy flag stays high for LOCK2_M0_TICKS pulses if the committed mode is 0, or LOCK2_M1_TICKS pulses if it is 1.
- R11: A new commit to a stage while its busy flag is high restarts that stage's window from its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| ref_tick | input | 1 | Reference-clock pulse enable for settling windows |
| pll1_div | output | 9 | Active first-stage divide ratio |
| pll1_mul | output | 9 | Active first-stage multiply ratio |
| pll2_div | output | 5 | Active second-stage divide ratio |
| pll2_mul | output | 5 | Active second-stage multiply ratio |
| mode_active | output | 1 | Active clock-generator mode |
| scale_en | output | 1 | 16/25 scaling applied |
| cfg_err | output | 1 | Sticky error: mode 1 committed with zero second-stage byte |
| pll1_busy | output | 1 | First-stage settling window running |
| pll2_busy | output | 1 | Second-stage settling window running |

## Verification
The bench targets several order-sensitive corner cases, each of which exposes a specific fault:

- **Stray write between divider and multiplier.** A sequencer that does not discard its pending divider would commit a stale pair.
- **Multiplier written alone.** A design that commits on every multiplier write would change the ratios with no divider write in front.
- **Mode bit written but not followed by address 9.** A mode that takes effect immediately would show up on `mode_active` too early.
- **Mode 1 committed with a zero byte.** Wrong handling here would either turn on scaling or fail to raise the sticky error. The bench also checks that the clear honours bit 0.
- **Settling windows.** The bench samples the windows on the last busy cycle and the first idle cycle, with `ref_tick` both held low and pulsing. It also issues a mid-window recommit. An off-by-one count, a timer that ignores `ref_tick`, or a timer that does not restart would each miss one of these samples.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int FIELD_W = DATA_W / 2;

    localparam logic [ADDR_W-1:0] A_P1_DIV = ADDR_W'(7);
    localparam logic [ADDR_W-1:0] A_P1_MUL = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_P2     = ADDR_W'(9);
    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(10);
    localparam logic [ADDR_W-1:0] A_ERRCLR = ADDR_W'(11);

    typedef enum logic {S1_IDLE, S1_ARMED} s1_state_t;
    typedef enum logic {T_IDLE, T_COUNT} tmr_state_t;
endpackage

// File: rtl/stage1_seq.sv
module stage1_seq
    import clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] div_q,
    output logic [DATA_W-1:0] mul_q,
    output logic              commit
);
    s1_state_t         state, nxt;
    logic [DATA_W-1:0] div_stage;
    logic              stage_ld;
    logic              hit_div, hit_mul;

    assign hit_div = wr_en && (wr_addr == A_P1_DIV);
    assign hit_mul = wr_en && (wr_addr == A_P1_MUL);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S1_IDLE;
        else     state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S1_IDLE:  if (hit_div) nxt = S1_ARMED;
            S1_ARMED: if (wr_en)   nxt = hit_div ? S1_ARMED : S1_IDLE;
            default:  nxt = S1_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        stage_ld = 1'b0;
        commit   = 1'b0;
        unique case (state)
            S1_IDLE:  stage_ld = hit_div;
            S1_ARMED: begin
                stage_ld = hit_div;
                commit   = hit_mul;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_stage <= '0;
            div_q     <= '0;
            mul_q     <= '0;
        end else begin
            if (stage_ld) div_stage <= wr_data;
            if (commit) begin
                div_q <= div_stage;
                mul_q <= wr_data;
            end
        end
    end

    AST_S1_COMMIT_ARMED: assert property (@(posedge clk) disable iff (rst)
        commit |-> ($past(hit_div) || state == S1_ARMED)) else $error("order"); // R2
    AST_S1_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hit_div && !hit_mul) |=> state == S1_IDLE) else $error("discard"); // R3
endmodule

// File: rtl/stage2_commit.sv
module stage2_commit
    import clkgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [FIELD_W-1:0] div_q,
    output logic [FIELD_W-1:0] mul_q,
    output logic               mode_q,
    output logic               scale_q,
    output logic               err_q,
    output logic               commit,
    output logic               commit_mode
);
    logic mode_shadow;
    logic hit_p2, hit_mode, hit_clr;
    logic byte_zero;

    assign hit_p2      = wr_en && (wr_addr == A_P2);
    assign hit_mode    = wr_en && (wr_addr == A_MODE);
    assign hit_clr     = wr_en && (wr_addr == A_ERRCLR);
    assign byte_zero   = (wr_data == '0);
    assign commit      = hit_p2;
    assign commit_mode = mode_shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_shadow <= 1'b0;
            div_q       <= '0;
            mul_q       <= '0;
            mode_q      <= 1'b0;
            scale_q     <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            if (hit_mode) mode_shadow <= wr_data[0];
            if (hit_p2) begin
                div_q   <= wr_data[DATA_W-1:FIELD_W];
                mul_q   <= wr_data[FIELD_W-1:0];
                mode_q  <= mode_shadow;
                scale_q <= mode_shadow && !byte_zero;
                if (mode_shadow && byte_zero) err_q <= 1'b1;
            end else if (hit_clr && wr_data[0]) begin
                err_q <= 1'b0;
            end
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q && !hit_clr) |=> err_q) else $error("sticky"); // R8
    AST_SCALE_MODE: assert property (@(posedge clk) disable iff (rst)
        scale_q |-> mode_q) else $error("scale"); // R7
endmodule

// File: rtl/settle_timer.sv
module settle_timer
    import clkgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             busy
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_t       state, nxt;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) state <= T_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            T_IDLE:  if (load && load_val != '0) nxt = T_COUNT;
            T_COUNT: begin
                if (load)                   nxt = (load_val != '0) ? T_COUNT : T_IDLE;
                else if (tick && cnt == ONE) nxt = T_IDLE;
            end
            default: nxt = T_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                               cnt <= '0;
        else if (load)                         cnt <= load_val;
        else if (state == T_COUNT && tick)     cnt <= cnt - ONE;
    end

    always_comb busy = (state == T_COUNT);

    AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> busy) else $error("load"); // R11
    AST_BUSY_SRC: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(load)) else $error("src"); // R9
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick && !load) |=> busy) else $error("hold"); // R9
endmodule

// File: rtl/clkgen_ratio_regs.sv
module clkgen_ratio_regs
    import clkgen_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int LOCK1_TICKS    = 1000,
    parameter int LOCK2_M0_TICKS = 500,
    parameter int LOCK2_M1_TICKS = 1000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               ref_tick,
    output logic [DATA_W:0]    pll1_div,
    output logic [DATA_W:0]    pll1_mul,
    output logic [FIELD_W:0]   pll2_div,
    output logic [FIELD_W:0]   pll2_mul,
    output logic               mode_active,
    output logic               scale_en,
    output logic               cfg_err,
    output logic               pll1_busy,
    output logic               pll2_busy
);
    localparam logic [CNT_W-1:0] L1    = CNT_W'(LOCK1_TICKS);
    localparam logic [CNT_W-1:0] L2_M0 = CNT_W'(LOCK2_M0_TICKS);
    localparam logic [CNT_W-1:0] L2_M1 = CNT_W'(LOCK2_M1_TICKS);

    logic [DATA_W-1:0]  n1, m1;
    logic [FIELD_W-1:0] n2, m2;
    logic               c1, c2, c2_mode;
    logic [CNT_W-1:0]   l2_val;

    stage1_seq u_s1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .div_q(n1), .mul_q(m1), .commit(c1)
    );

    stage2_commit u_s2 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .div_q(n2), .mul_q(m2), .mode_q(mode_active), .scale_q(scale_en),
        .err_q(cfg_err), .commit(c2), .commit_mode(c2_mode)
    );

    assign l2_val = c2_mode ? L2_M1 : L2_M0;

    settle_timer #(.CNT_W(CNT_W)) u_t1 (
        .clk(clk), .rst(rst), .load(c1), .load_val(L1), .tick(ref_tick), .busy(pll1_busy)
    );

    settle_timer #(.CNT_W(CNT_W)) u_t2 (
        .clk(clk), .rst(rst), .load(c2), .load_val(l2_val), .tick(ref_tick), .busy(pll2_busy)
    );

    always_comb begin
        pll1_div = {1'b0, n1} + (DATA_W+1)'(1);
        pll1_mul = {1'b0, m1} + (DATA_W+1)'(1);
        pll2_div = {1'b0, n2} + (FIELD_W+1)'(1);
        pll2_mul = {1'b0, m2} + (FIELD_W+1)'(1);
    end

    AST_P1_ONLY_ON_MUL: assert property (@(posedge clk) disable iff (rst)
        (!$stable(pll1_div) || !$stable(pll1_mul)) |-> $past(wr_en && wr_addr == A_P1_MUL))
        else $error("p1"); // R2
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_active) |-> $past(wr_en && wr_addr == A_P2)) else $error("mode"); // R6
    AST_ERR_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_err) |-> $past(wr_en && wr_addr == A_P2)) else $error("err"); // R8
endmodule

// File: tb/clkgen_ratio_regs_test.sv
module clkgen_ratio_regs_test;
    localparam int L1 = 20, L2M0 = 6, L2M1 = 30;

    logic       clk = 1'b0, rst = 1'b1, wr_en = 1'b0, ref_tick = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [8:0] pll1_div, pll1_mul;
    logic [4:0] pll2_div, pll2_mul;
    logic       mode_active, scale_en, cfg_err, pll1_busy, pll2_busy;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clkgen_ratio_regs #(.CNT_W(16), .LOCK1_TICKS(L1), .LOCK2_M0_TICKS(L2M0),
                        .LOCK2_M1_TICKS(L2M1)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ref_tick(ref_tick), .pll1_div(pll1_div), .pll1_mul(pll1_mul),
        .pll2_div(pll2_div), .pll2_mul(pll2_mul), .mode_active(mode_active),
        .scale_en(scale_en), .cfg_err(cfg_err), .pll1_busy(pll1_busy), .pll2_busy(pll2_busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 pll1_div", pll1_div, 1);
        chk("R1 pll1_mul", pll1_mul, 1);
        chk("R1 pll2_div", pll2_div, 1);
        chk("R1 pll2_mul", pll2_mul, 1);
        chk("R1 mode", mode_active, 0);
        chk("R1 scale", scale_en, 0);
        chk("R1 err", cfg_err, 0);
        chk("R1 busy1", pll1_busy, 0);
        chk("R1 busy2", pll2_busy, 0);
    endtask

    task automatic t_pll1_order();
        wr(4'd7, 8'h7C);
        chk("R2 div not yet", pll1_div, 1);
        wait_edges(3);
        wr(4'd8, 8'h5F);
        chk("R5 div 0x7C", pll1_div, 125);
        chk("R5 mul 0x5F", pll1_mul, 96);
    endtask

    task automatic t_pll1_break();
        wr(4'd7, 8'h01);
        wr(4'd10, 8'h00);
        wr(4'd8, 8'h02);
        chk("R3 stray write div", pll1_div, 125);
        chk("R3 stray write mul", pll1_mul, 96);
        wr(4'd8, 8'h09);
        chk("R3 lone mul", pll1_mul, 96);
        wr(4'd7, 8'h10);
        wr(4'd7, 8'h20);
        wr(4'd8, 8'h03);
        chk("R4 newest div", pll1_div, 33);
        chk("R4 mul", pll1_mul, 4);
    endtask

    task automatic t_mode();
        wr(4'd10, 8'h01);
        chk("R6 mode held", mode_active, 0);
        wr(4'd9, 8'h34);
        chk("R6 mode applied", mode_active, 1);
        chk("R5 pll2_div", pll2_div, 4);
        chk("R5 pll2_mul", pll2_mul, 5);
        chk("R7 scale on", scale_en, 1);
        wr(4'd10, 8'h00);
        chk("R6 mode still 1", mode_active, 1);
        wr(4'd9, 8'h12);
        chk("R6 mode 0", mode_active, 0);
        chk("R7 scale off mode0", scale_en, 0);
    endtask

    task automatic t_err();
        wr(4'd10, 8'h01);
        wr(4'd9, 8'h00);
        chk("R7 scale off zero", scale_en, 0);
        chk("R8 err set", cfg_err, 1);
        chk("R5 pll2_div zero", pll2_div, 1);
        wr(4'd9, 8'h55);
        chk("R8 err sticky", cfg_err, 1);
        wr(4'd11, 8'h00);
        chk("R8 clr bit0=0", cfg_err, 1);
        wr(4'd11, 8'h01);
        chk("R8 cleared", cfg_err, 0);
    endtask

    task automatic t_busy1();
        ref_tick = 1'b1;
        wr(4'd7, 8'h05);
        wr(4'd8, 8'h06);
        chk("R9 busy at commit", pll1_busy, 1);
        wait_edges(L1 - 1);
        chk("R9 last busy", pll1_busy, 1);
        wait_edges(1);
        chk("R9 idle", pll1_busy, 0);
        ref_tick = 1'b0;
        wr(4'd7, 8'h05);
        wr(4'd8, 8'h06);
        wait_edges(2 * L1);
        chk("R9 hold no tick", pll1_busy, 1);
        ref_tick = 1'b1;
        wait_edges(L1);
        chk("R9 idle after ticks", pll1_busy, 0);
    endtask

    task automatic t_busy2();
        ref_tick = 1'b1;
        wr(4'd10, 8'h00);
        wr(4'd9, 8'h11);
        wait_edges(L2M0 - 1);
        chk("R10 mode0 last busy", pll2_busy, 1);
        wait_edges(1);
        chk("R10 mode0 idle", pll2_busy, 0);
        wr(4'd10, 8'h01);
        wr(4'd9, 8'h11);
        wait_edges(L2M1 - 1);
        chk("R10 mode1 last busy", pll2_busy, 1);
        wait_edges(1);
        chk("R10 mode1 idle", pll2_busy, 0);
    endtask

    task automatic t_retrigger();
        ref_tick = 1'b1;
        wr(4'd7, 8'h01);
        wr(4'd8, 8'h01);
        wait_edges(10);
        wr(4'd7, 8'h02);
        wr(4'd8, 8'h02);
        wait_edges(L1 - 1);
        chk("R11 restarted busy", pll1_busy, 1);
        wait_edges(1);
        chk("R11 idle", pll1_busy, 0);
        ref_tick = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pll1_order();
        t_pll1_break();
        t_mode();
        t_err();
        t_busy1();
        t_busy2();
        t_retrigger();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule